// File: doc/BRIEF.md
# Blowfish S-box Storage Controller

This block owns the S-box storage of a single bcrypt-style Blowfish key-setup engine. Four dual-port memories of 1024 words by 32 bits hold the S-boxes. The lower 512 words of each memory form a working area that holds two S-boxes. The upper 512 words carry a preloaded copy of the initial S-box contents, and nothing ever writes them. The memories are arranged as two mirrored pairs. Memories 0 and 2 hold boxes 0 and 1, and memories 1 and 3 hold boxes 2 and 3. Because of the mirroring, each of the four boxes can be read through a single port A.

A start request copies the pristine upper halves into the working halves, using both ports of every memory. Key expansion then feeds the block one L/R word pair per accepted cycle. A word pointer steers each pair to one of two places: the 18-entry P-array register file, or two consecutive words of the S-box working area. While expansion runs, the round function reads the four boxes through a lookup port that has a fixed latency.

The initial image lives in the spare half of memories that are already in place. Restoring the boxes between keys therefore costs only copy cycles and adds no storage.

Top module: `sbox_store`

## Requirements
- R1: After reset, ready_o and key_done_o are low and all 18 P-array entries read zero.
- R2: A start_i sampled high begins a restore and drops ready_o from the next cycle. The restore is 256 copy steps of two clocks each: a read clock, then a write clock. ready_o rises exactly 512 clock edges after the edge that sampled start_i. A new start_i during a restore begins the count again.
- R3: After a restore, box k at index i (k in 0..3, i in 0..255) holds the seed word for pair p = k/2 and offset j = (k mod 2)*256 + i. The seed word is computed as ((p*512 + j + 1) * 0x9E3779B1 mod 2^32) XOR 0xC3A50F1E. This same word was preloaded at upper address 512 + j of each memory in pair p.
- R4: No write ever reaches an address with bit 9 set. Every later restore therefore reproduces the contents of R3 exactly, even after the working halves have been overwritten.
- R5: The lookup port takes box k's 8-bit index on lk_idx_i[8k+7:8k] and returns that box's word on lk_data_o[32k+31:32k]. The word appears one clock edge after the index is applied, while no restore or L/R write is in progress.
- R6: An L/R pair is accepted when lr_valid_i is high, ready_o is high and expansion has not finished. The word pointer starts at 0 after each restore and advances by 2 per accepted pair. When the pointer is below 18, L goes to P entry pointer and R goes to P entry pointer+1. P entries are read combinationally through p_idx_i/p_data_o.
- R7: When the pointer is between 18 and 1040, L goes to S stream word pointer-18 and R goes to S stream word pointer-17. Stream word w is entry w mod 256 of box w/256. Words 0..511 are written to both memories of pair 0, and words 512..1023 to both memories of pair 1.
- R8: key_done_o pulses high for exactly one cycle, on the edge that accepts the pair at pointer 1040. No pair after that changes the P-array or the S-boxes until the next start.
- R9: L/R pairs offered while ready_o is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a restore of the working S-boxes |
| ready_o | output | 1 | Restore complete; expansion and lookups allowed |
| lr_valid_i | input | 1 | An L/R pair is offered |
| lr_left_i | input | 32 | L word of the pair |
| lr_right_i | input | 32 | R word of the pair |
| key_done_o | output | 1 | One-cycle pulse when the last pair has been stored |
| p_idx_i | input | 5 | P-array entry to read |
| p_data_o | output | 32 | Selected P-array entry |
| lk_idx_i | input | 32 | Four packed 8-bit box indices, box k in bits 8k+7:8k |
| lk_data_o | output | 128 | Four packed box words, box k in bits 32k+31:32k |

## Verification
The bench sweeps all 256 indices of all four boxes after a restore, after a full 521-pair expansion, and after a restart-interrupted second restore. Each result is compared with arithmetic built from the seed formula and the L/R generators.

A design that let address bit 9 float during a write would leave the second restore showing expansion data instead of seed words. Any slip in the 18 or 17 offsets, or in the pair split at pointer 530, shifts or mirrors stream words into the wrong box entries. An error in the copy pipeline shows up as wrong odd words or as the wrong restore length.

The bench also covers the remaining edges of the protocol. It confirms that the done pulse comes on the edge of the pair at pointer 1040 and lasts one cycle. It offers a pair after completion, and another before the first restore, and checks that neither changes stored state.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int WORD_W    = 32;
    localparam int MEM_AW    = 10;
    localparam int N_MEM     = 4;
    localparam int P_LEN     = 18;

    localparam int MEM_DEPTH = 1 << MEM_AW;
    localparam int HALF      = MEM_DEPTH / 2;
    localparam int HALF_AW   = MEM_AW - 1;
    localparam int BOX_AW    = HALF_AW - 1;
    localparam int N_PAIR    = N_MEM / 2;
    localparam int S_WORDS   = N_PAIR * HALF;
    localparam int PTR_W     = $clog2(P_LEN + S_WORDS);
    localparam int PTR_LAST  = P_LEN + S_WORDS - 2;
    localparam int STEPS     = HALF / 2;
    localparam int STEP_W    = HALF_AW - 1;
    localparam int P_IDX_W   = $clog2(P_LEN);
    localparam int LK_IDX_W  = N_MEM * BOX_AW;
    localparam int LK_DAT_W  = N_MEM * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [MEM_AW-1:0] maddr_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef struct packed {
        logic   we;
        maddr_t addr;
        word_t  wd;
    } port_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESTORE,
        ST_EXPAND,
        ST_FINISHED
    } ctl_state_t;

    // Seed image placed in the upper half of each memory of a pair.
    function automatic word_t seed_word(int unsigned pair, int unsigned j);
        word_t k;
        k = word_t'(pair * HALF + j + 1);
        return (k * 32'h9E3779B1) ^ 32'hC3A50F1E;
    endfunction

    // Box served by the port-A lookup of memory m.
    function automatic int unsigned box_of_mem(int unsigned m);
        return 2 * (m % 2) + m / 2;
    endfunction

endpackage

// File: rtl/sbox_dpram.sv
module sbox_dpram
    import sbox_pkg::*;
#(
    parameter int PAIR = 0
) (
    input  logic      clk,
    input  port_cmd_t cmd_a,
    input  port_cmd_t cmd_b,
    output word_t     rd_a,
    output word_t     rd_b
);

    word_t mem [MEM_DEPTH];

    initial begin
        for (int i = 0; i < MEM_DEPTH; i++) begin
            mem[i] = (i >= HALF) ? seed_word(PAIR, i - HALF) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (cmd_a.we) mem[cmd_a.addr] <= cmd_a.wd;
        rd_a <= mem[cmd_a.addr];
    end

    always_ff @(posedge clk) begin
        if (cmd_b.we) mem[cmd_b.addr] <= cmd_b.wd;
        rd_b <= mem[cmd_b.addr];
    end

endmodule

// File: rtl/sbox_restore_seq.sv
module sbox_restore_seq
    import sbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              active,
    output logic              wr_phase,
    output logic [STEP_W-1:0] step,
    output logic              fin
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

    assign fin = active && wr_phase && (step == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            wr_phase <= 1'b0;
            step     <= '0;
        end else if (start) begin
            active   <= 1'b1;
            wr_phase <= 1'b0;
            step     <= '0;
        end else if (active) begin
            wr_phase <= ~wr_phase;
            if (wr_phase) begin
                step <= step + 1'b1;
                if (step == LAST_STEP) active <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sbox_route.sv
module sbox_route
    import sbox_pkg::*;
(
    input  logic                rs_active,
    input  logic                rs_wr,
    input  logic [STEP_W-1:0]   rs_step,
    input  logic                accept,
    input  ptr_t                ptr,
    input  word_t               left_w,
    input  word_t               right_w,
    input  logic [LK_IDX_W-1:0] lk_idx,
    input  word_t               rd_a [N_MEM],
    input  word_t               rd_b [N_MEM],
    output port_cmd_t           cmd_a [N_MEM],
    output port_cmd_t           cmd_b [N_MEM],
    output logic                p_we
);

    logic [HALF_AW:0]    s_off;
    logic                s_pair;
    logic [HALF_AW-1:0]  s_loc;

    assign s_off  = (HALF_AW + 1)'(ptr - PTR_W'(P_LEN));
    assign s_pair = s_off[HALF_AW];
    assign s_loc  = s_off[HALF_AW-1:0];

    always_comb begin
        p_we = 1'b0;
        for (int m = 0; m < N_MEM; m++) begin
            cmd_a[m] = '0;
            cmd_b[m] = '0;
            if (rs_active) begin
                if (!rs_wr) begin
                    cmd_a[m].addr = {1'b1, rs_step, 1'b0};
                    cmd_b[m].addr = {1'b1, rs_step, 1'b1};
                end else begin
                    cmd_a[m].we   = 1'b1;
                    cmd_a[m].addr = {1'b0, rs_step, 1'b0};
                    cmd_a[m].wd   = rd_a[m];
                    cmd_b[m].we   = 1'b1;
                    cmd_b[m].addr = {1'b0, rs_step, 1'b1};
                    cmd_b[m].wd   = rd_b[m];
                end
            end else if (accept) begin
                if (ptr >= PTR_W'(P_LEN) && (1'(m % 2) == s_pair)) begin
                    cmd_a[m].we   = 1'b1;
                    cmd_a[m].addr = {1'b0, s_loc};
                    cmd_a[m].wd   = left_w;
                    cmd_b[m].we   = 1'b1;
                    cmd_b[m].addr = {1'b0, s_loc + 1'b1};
                    cmd_b[m].wd   = right_w;
                end
            end else begin
                cmd_a[m].addr = {1'b0, 1'(m / 2),
                                 lk_idx[BOX_AW*box_of_mem(m) +: BOX_AW]};
            end
        end
        if (!rs_active && accept && ptr < PTR_W'(P_LEN)) p_we = 1'b1;
    end

endmodule

// File: rtl/sbox_parray.sv
module sbox_parray
    import sbox_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [P_IDX_W-1:0] wr_idx,
    input  word_t              wd_even,
    input  word_t              wd_odd,
    input  logic [P_IDX_W-1:0] rd_idx,
    output word_t              rd_data
);

    word_t regs [P_LEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < P_LEN; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wr_idx]        <= wd_even;
            regs[wr_idx + 1'b1] <= wd_odd;
        end
    end

    assign rd_data = (rd_idx < P_IDX_W'(P_LEN)) ? regs[rd_idx] : '0;

endmodule

// File: rtl/sbox_store.sv
module sbox_store
    import sbox_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    output logic                ready_o,
    input  logic                lr_valid_i,
    input  logic [31:0]         lr_left_i,
    input  logic [31:0]         lr_right_i,
    output logic                key_done_o,
    input  logic [4:0]          p_idx_i,
    output logic [31:0]         p_data_o,
    input  logic [31:0]         lk_idx_i,
    output logic [127:0]        lk_data_o
);

    ctl_state_t          state;
    ptr_t                ptr;
    logic                accept;
    logic                done_q;
    logic                rs_active, rs_wr, rs_fin;
    logic [STEP_W-1:0]   rs_step;
    logic                p_we;
    port_cmd_t           cmd_a [N_MEM];
    port_cmd_t           cmd_b [N_MEM];
    word_t               rd_a  [N_MEM];
    word_t               rd_b  [N_MEM];

    assign accept     = lr_valid_i && !start_i && (state == ST_EXPAND);
    assign ready_o    = (state == ST_EXPAND) || (state == ST_FINISHED);
    assign key_done_o = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= accept && (ptr == PTR_W'(PTR_LAST));
            if (start_i) begin
                state <= ST_RESTORE;
                ptr   <= '0;
            end else if (state == ST_RESTORE && rs_fin) begin
                state <= ST_EXPAND;
            end else if (accept) begin
                ptr <= ptr + PTR_W'(2);
                if (ptr == PTR_W'(PTR_LAST)) state <= ST_FINISHED;
            end
        end
    end

    sbox_restore_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .active   (rs_active),
        .wr_phase (rs_wr),
        .step     (rs_step),
        .fin      (rs_fin)
    );

    sbox_route u_route (
        .rs_active (rs_active),
        .rs_wr     (rs_wr),
        .rs_step   (rs_step),
        .accept    (accept),
        .ptr       (ptr),
        .left_w    (lr_left_i),
        .right_w   (lr_right_i),
        .lk_idx    (lk_idx_i),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .cmd_a     (cmd_a),
        .cmd_b     (cmd_b),
        .p_we      (p_we)
    );

    sbox_parray u_parr (
        .clk     (clk),
        .rst     (rst),
        .we      (p_we),
        .wr_idx  (P_IDX_W'(ptr)),
        .wd_even (lr_left_i),
        .wd_odd  (lr_right_i),
        .rd_idx  (p_idx_i),
        .rd_data (p_data_o)
    );

    for (genvar m = 0; m < N_MEM; m++) begin : g_mem
        sbox_dpram #(.PAIR(m % 2)) u_ram (
            .clk   (clk),
            .cmd_a (cmd_a[m]),
            .cmd_b (cmd_b[m]),
            .rd_a  (rd_a[m]),
            .rd_b  (rd_b[m])
        );
        assign lk_data_o[WORD_W*box_of_mem(m) +: WORD_W] = rd_a[m];
    end

endmodule

// File: rtl/sbox_store_chk.sv
module sbox_store_chk
    import sbox_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start_i,
    input logic      ready_o,
    input logic      key_done_o,
    input logic      rs_active,
    input logic      rs_wr,
    input port_cmd_t cmd_a [N_MEM],
    input port_cmd_t cmd_b [N_MEM]
);

    for (genvar m = 0; m < N_MEM; m++) begin : g_port
        assert_upper_safe_a_R4: assert property (@(posedge clk) disable iff (rst)
            cmd_a[m].we |-> !cmd_a[m].addr[MEM_AW-1]);
        assert_upper_safe_b_R4: assert property (@(posedge clk) disable iff (rst)
            cmd_b[m].we |-> !cmd_b[m].addr[MEM_AW-1]);
        assert_copy_reads_seed_R3: assert property (@(posedge clk) disable iff (rst)
            (rs_active && !rs_wr) |-> (cmd_a[m].addr[MEM_AW-1] && cmd_b[m].addr[MEM_AW-1]
                                       && !cmd_a[m].we && !cmd_b[m].we));
    end

    assert_start_drops_ready_R2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !ready_o);
    assert_ready_held_R2: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i) |=> ready_o);
    assert_ready_from_copy_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(rs_active));
    assert_not_ready_while_copy_R2: assert property (@(posedge clk) disable iff (rst)
        rs_active |-> !ready_o);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        key_done_o |=> !key_done_o);
    assert_done_when_ready_R8: assert property (@(posedge clk) disable iff (rst)
        key_done_o |-> ready_o);

endmodule

bind sbox_store sbox_store_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ready_o    (ready_o),
    .key_done_o (key_done_o),
    .rs_active  (rs_active),
    .rs_wr      (rs_wr),
    .cmd_a      (cmd_a),
    .cmd_b      (cmd_b)
);

// File: tb/tb_sbox_store.sv
`timescale 1ns/1ps
module tb_sbox_store;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         lr_valid_i = 1'b0;
    logic [31:0]  lr_left_i = '0;
    logic [31:0]  lr_right_i = '0;
    logic [4:0]   p_idx_i = '0;
    logic [31:0]  lk_idx_i = '0;
    logic         ready_o, key_done_o;
    logic [31:0]  p_data_o;
    logic [127:0] lk_data_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sbox_store dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ready_o    (ready_o),
        .lr_valid_i (lr_valid_i),
        .lr_left_i  (lr_left_i),
        .lr_right_i (lr_right_i),
        .key_done_o (key_done_o),
        .p_idx_i    (p_idx_i),
        .p_data_o   (p_data_o),
        .lk_idx_i   (lk_idx_i),
        .lk_data_o  (lk_data_o)
    );

    function automatic logic [31:0] seed(int pair, int j);
        logic [31:0] k;
        k = 32'(pair * 512 + j + 1);
        return (k * 32'h9E3779B1) ^ 32'hC3A50F1E;
    endfunction

    function automatic logic [31:0] lval(int n);
        return 32'h0BAD0000 ^ (32'(n) * 32'h01000193);
    endfunction

    function automatic logic [31:0] rval(int n);
        return (32'(n) * 32'h2545F491) ^ 32'h7F00FF00;
    endfunction

    // Word written to S stream position w by the full expansion run.
    function automatic logic [31:0] stream_word(int w);
        int n;
        n = (w + 18) / 2;
        return (w % 2 == 0) ? lval(n) : rval(n);
    endfunction

    function automatic logic [31:0] p_word(int k);
        return (k % 2 == 0) ? lval(k / 2) : rval(k / 2);
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic restore(string req, int restart_after);
        int cnt;
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        check32(req, 32'(ready_o), 32'd0);
        if (restart_after > 0) begin
            for (int i = 0; i < restart_after; i++) tick();
            check32(req, 32'(ready_o), 32'd0);
            start_i = 1'b1;
            tick();
            start_i = 1'b0;
        end
        cnt = 0;
        while (!ready_o && cnt < 2000) begin
            tick();
            cnt++;
        end
        check32(req, 32'(cnt), 32'd512);
    endtask

    // mode 0: seed contents; mode 1: after the full expansion
    task automatic sweep(string req, int mode);
        int ix [4];
        logic [31:0] exp;
        for (int i = 0; i < 256; i++) begin
            ix[0] = i;
            ix[1] = 255 - i;
            ix[2] = i ^ 8'h55;
            ix[3] = (i + 17) % 256;
            lk_idx_i = {8'(ix[3]), 8'(ix[2]), 8'(ix[1]), 8'(ix[0])};
            tick();
            for (int k = 0; k < 4; k++) begin
                if (mode == 0) exp = seed(k / 2, (k % 2) * 256 + ix[k]);
                else           exp = stream_word(k * 256 + ix[k]);
                check32(req, lk_data_o[32*k +: 32], exp);
            end
        end
    endtask

    task automatic check_parray(string req, int zero);
        for (int k = 0; k < 18; k++) begin
            p_idx_i = 5'(k);
            #0.1;
            check32(req, p_data_o, zero ? 32'd0 : p_word(k));
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int early_done;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        check32("R1 ready", 32'(ready_o), 32'd0);
        check32("R1 done", 32'(key_done_o), 32'd0);
        check_parray("R1 parray", 1);

        // R9: a pair offered before any restore is dropped
        lr_valid_i = 1'b1; lr_left_i = 32'hDEADBEEF; lr_right_i = 32'hFEEDF00D;
        tick();
        lr_valid_i = 1'b0;
        check_parray("R9 parray", 1);

        // R2: restore length
        restore("R2 restore", 0);
        // R3/R5: full sweep of seed contents with distinct index patterns
        sweep("R3 R5 seed lookup", 0);

        // R6/R7/R8: full expansion
        early_done = 0;
        for (int n = 0; n < 521; n++) begin
            lr_valid_i = 1'b1;
            lr_left_i  = lval(n);
            lr_right_i = rval(n);
            tick();
            if (n < 520 && key_done_o) early_done++;
        end
        check32("R8 done pulse", 32'(key_done_o), 32'd1);
        check32("R8 no early done", 32'(early_done), 32'd0);
        // R8: pair after completion is ignored
        lr_left_i  = 32'h11111111;
        lr_right_i = 32'h22222222;
        tick();
        lr_valid_i = 1'b0;
        check32("R8 single pulse", 32'(key_done_o), 32'd0);
        tick();
        check32("R8 still ready", 32'(ready_o), 32'd1);
        check_parray("R6 parray", 0);
        sweep("R7 R8 expanded lookup", 1);

        // R2/R4: interrupted restore, then seed contents must reappear
        restore("R2 restart", 100);
        sweep("R4 seed after rewrite", 0);
        check_parray("R4 parray kept", 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule